// File: doc/BRIEF.md
# Two-Domain Multiplexed Scan Chain

This block is a bank of edge-triggered storage cells whose contents can be reached through a serial path. Every cell has a two-way input multiplexer. With scan enable low, each cell stores its own functional data bit on the rising edge of its clock. With scan enable high, the cells ignore their functional data and form one shift register. The register runs from the scan input through all cells to the scan output.

The chain starts with `N_A` cells clocked by `clk_a_i` and continues with `N_B` cells clocked by `clk_b_i`. The two clocks run at the same rate but may be skewed against each other. A latch that is transparent while `clk_a_i` is low sits between the last A cell and the first B cell. After each rising edge of `clk_a_i` it keeps the old bit on offer for half a period. A late `clk_b_i` edge therefore still takes the bit that was meant for it.

The full contents of the chain are driven on `state_o`. Bit 0 is the first A cell and the highest bit is the last B cell.

Top module: `scan_chain_2dom`

## Requirements
- R1: While `rst_ni` is low, every cell and the lock-up latch read 0, so `state_o` and `scan_out_o` are 0. This holds even when the functional inputs are non-zero and the clocks run. Reset takes effect without waiting for a clock edge.
- R2: With `scan_en_i` at 0 (capture), a rising edge of each domain's clock loads that domain's cells from their functional inputs. After the edges, `state_o[N_A-1:0]` equals `func_a_i` and `state_o[N_A+N_B-1:N_A]` equals `func_b_i`.
- R3: With `scan_en_i` at 1 (shift), one clock period moves the chain by exactly one position. Bit 0 of `state_o` takes `scan_in_i`, and bit k takes the old bit k-1.
- R4: During shift, the values on `func_a_i` and `func_b_i` have no effect on any cell.
- R5: `scan_out_o` always equals the last cell of the chain, `state_o[N_A+N_B-1]`. A bit entered at `scan_in_i` appears there after exactly `N_A+N_B` shift periods.
- R6: With `clk_b_i` rising up to a quarter period after `clk_a_i`, the first B cell takes the value the last A cell held before that period's `clk_a_i` edge. No bit is duplicated or lost at the domain boundary.
- R7: The lock-up latch passes its input while `clk_a_i` is low. It holds the value it had at the rising edge of `clk_a_i` throughout the high phase.
- R8: `scan_en_i` may change every period. Each period is processed in the mode present at its edge, so a capture followed directly by shifts unloads the captured word in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_i | input | 1 | Clock of the first segment (cells 0..N_A-1) |
| clk_b_i | input | 1 | Clock of the second segment (cells N_A..N_A+N_B-1) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | 0 = capture functional data, 1 = shift |
| scan_in_i | input | 1 | Serial input into cell 0 |
| func_a_i | input | N_A | Functional data of the first segment |
| func_b_i | input | N_B | Functional data of the second segment |
| scan_out_o | output | 1 | Serial output, last cell of the chain |
| state_o | output | N_A+N_B | Contents of all cells in chain order |

## Verification
If the lock-up latch is wrong, the first B cell takes a bit one period early at the first skewed shift. `state_o` then shows a duplicated bit at index `N_A` in the same period. A wrong multiplexer select or a broken link shows as a mismatch on `state_o` within one edge of the faulty capture or shift. The same error reaches `scan_out_o` within at most `N_A+N_B` periods. The bench sweeps every capture word and every shift pattern of a 3+4 chain, with the B clock lagging by a quarter period. It compares the chain against an arithmetic shift model after every period.

// File: rtl/scan_chain_pkg.sv
`timescale 1ns/1ps
package scan_chain_pkg;
  typedef enum logic {
    SE_CAPTURE = 1'b0,
    SE_SHIFT   = 1'b1
  } scan_mode_e;

  localparam int unsigned DEF_CELLS_A = 8;
  localparam int unsigned DEF_CELLS_B = 8;
endpackage

// File: rtl/scan_cell.sv
`timescale 1ns/1ps
module scan_cell
  import scan_chain_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic se_i,
  input  logic d_i,
  input  logic si_i,
  output logic q_o
);
  scan_mode_e mode;
  assign mode = scan_mode_e'(se_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= 1'b0;
    else if (mode == SE_SHIFT)  q_o <= si_i;
    else                        q_o <= d_i;
  end

  p_shift_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se_i |=> (q_o == $past(si_i)));

  p_capture_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !se_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/scan_segment.sv
`timescale 1ns/1ps
module scan_segment #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         se_i,
  input  logic         si_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic         so_o
);
  logic [N:0] link;
  assign link[0] = si_i;

  for (genvar g = 0; g < N; g++) begin : g_cell
    scan_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .se_i   (se_i),
      .d_i    (d_i[g]),
      .si_i   (link[g]),
      .q_o    (link[g+1])
    );
  end

  assign q_o  = link[N:1];
  assign so_o = link[N];
endmodule

// File: rtl/scan_lockup.sv
`timescale 1ns/1ps
module scan_lockup (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  // open in the low phase, closed in the high phase of the source clock
  always_latch begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (!clk_i) q_o <= d_i;
  end

  // checker state: input as seen just before the closing edge
  logic d_at_close;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_at_close <= 1'b0;
    else         d_at_close <= d_i;
  end

  p_lockup_hold_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    q_o == d_at_close);
endmodule

// File: rtl/scan_chain_2dom.sv
`timescale 1ns/1ps
module scan_chain_2dom
  import scan_chain_pkg::*;
#(
  parameter int unsigned N_A = DEF_CELLS_A,
  parameter int unsigned N_B = DEF_CELLS_B
) (
  input  logic               clk_a_i,
  input  logic               clk_b_i,
  input  logic               rst_ni,
  input  logic               scan_en_i,
  input  logic               scan_in_i,
  input  logic [N_A-1:0]     func_a_i,
  input  logic [N_B-1:0]     func_b_i,
  output logic               scan_out_o,
  output logic [N_A+N_B-1:0] state_o
);
  localparam int unsigned N_ALL = N_A + N_B;

  logic [N_A-1:0] q_a;
  logic [N_B-1:0] q_b;
  logic           so_a;
  logic           lock_q;
  logic           so_b;

  scan_segment #(.N(N_A)) u_seg_a (
    .clk_i  (clk_a_i),
    .rst_ni (rst_ni),
    .se_i   (scan_en_i),
    .si_i   (scan_in_i),
    .d_i    (func_a_i),
    .q_o    (q_a),
    .so_o   (so_a)
  );

  // source-side lock-up element at the domain crossing
  scan_lockup u_lockup (
    .clk_i  (clk_a_i),
    .rst_ni (rst_ni),
    .d_i    (so_a),
    .q_o    (lock_q)
  );

  scan_segment #(.N(N_B)) u_seg_b (
    .clk_i  (clk_b_i),
    .rst_ni (rst_ni),
    .se_i   (scan_en_i),
    .si_i   (lock_q),
    .d_i    (func_b_i),
    .q_o    (q_b),
    .so_o   (so_b)
  );

  assign state_o    = {q_b, q_a};
  assign scan_out_o = so_b;

  p_boundary_shift_r6: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    scan_en_i |=> (q_b[0] == $past(lock_q)));

  if (N_ALL > 1) begin : g_tail_chk
    p_out_follows_r5: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
      scan_en_i |=> (scan_out_o == $past(state_o[N_ALL-2])));
  end
endmodule

// File: tb/sim_scan_chain_2dom.sv
`timescale 1ns/1ps
module sim_scan_chain_2dom;
  localparam int NA = 3;
  localparam int NB = 4;
  localparam int N  = NA + NB;

  logic          clk_a, clk_b, rst_ni, scan_en, scan_in;
  logic [NA-1:0] func_a;
  logic [NB-1:0] func_b;
  logic          scan_out;
  logic [N-1:0]  state;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model;
  bit done = 0;

  scan_chain_2dom #(.N_A(NA), .N_B(NB)) u0 (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_ni),
    .scan_en_i(scan_en), .scan_in_i(scan_in),
    .func_a_i(func_a), .func_b_i(func_b),
    .scan_out_o(scan_out), .state_o(state)
  );

  // 250 MHz; B clock lags A by 1 ns (quarter period)
  initial begin clk_a = 0; forever #2 clk_a = ~clk_a; end
  initial begin clk_b = 0; #1; forever #2 clk_b = ~clk_b; end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive, then one period; sample 2.5 ns after the A edge
  task automatic step(input logic se, input logic si, input logic [NA-1:0] fa,
                      input logic [NB-1:0] fb, input string req);
    logic [N-1:0] prev;
    scan_en = se; scan_in = si; func_a = fa; func_b = fb;
    prev = model;
    @(posedge clk_a); #2.5;
    if (se) model = {prev[N-2:0], si};
    else    model = {fb, fa};
    chk(req, state, model);
    chk("R5 scan_out", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, model[N-1]});
    if (se) chk("R6 boundary", {{(N-1){1'b0}}, state[NA]}, {{(N-1){1'b0}}, prev[NA-1]});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; scan_en = 0; scan_in = 1; func_a = '1; func_b = '1;
    model = '0;
    #0.5;
    chk("R1 reset", state, '0);
    repeat (3) @(posedge clk_a);
    #2.5;
    chk("R1 reset under clocks", state, '0);
    chk("R1 scan_out", {{(N-1){1'b0}}, scan_out}, '0);
    rst_ni = 1;

    // R2: every capture word
    for (int w = 0; w < (1 << N); w++)
      step(1'b0, 1'b1, w[NA-1:0], w[N-1:NA], "R2 capture");

    // R3/R4: every shift pattern, functional inputs toggling
    for (int p = 0; p < (1 << N); p++) begin
      for (int b = 0; b < N; b++) begin
        logic [N-1:0] junk;
        junk = N'(p * 5 + b * 3) ^ {N{b[0]}};
        step(1'b1, p[N-1-b], junk[NA-1:0], junk[N-1:NA], "R3/R4 shift");
      end
      chk("R3 full load", state, N'(p));
    end

    // R8: capture then unload, in-order on scan_out (R5 latency)
    for (int t = 0; t < 16; t++) begin
      logic [N-1:0] word;
      word = N'(t * 37 + 11);
      step(1'b0, 1'b0, word[NA-1:0], word[N-1:NA], "R8 capture");
      for (int k = 0; k < N; k++) begin
        chk("R8 unload order", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, word[N-1-k]});
        step(1'b1, 1'b0, ~word[NA-1:0], ~word[N-1:NA], "R8 shift");
      end
      chk("R5 drained", state, '0);
    end

    // R8: mode alternating each period
    for (int t = 0; t < 64; t++) begin
      logic [N-1:0] r;
      r = N'(t * 29 + 7);
      step(r[0] ^ r[3], r[1], r[NA-1:0], r[N-1:NA], "R8 mixed");
    end

    // R7: latch holds through A high phase; entering 1 after zeros crosses in one period only
    for (int k = 0; k < N; k++) step(1'b1, 1'b0, '0, '0, "R7 flush");
    for (int k = 0; k < NA; k++) step(1'b1, (k == 0), '0, '0, "R7 walk");
    chk("R7 bit at A end", state, N'(1) << (NA - 1));
    step(1'b1, 1'b0, '0, '0, "R7 cross");
    chk("R7 single crossing", state, N'(1) << NA);

    // R1: asynchronous reset mid-run
    step(1'b0, 1'b0, '1, '1, "R1 preload");
    rst_ni = 0;
    #0.5;
    chk("R1 async clear", state, '0);
    @(posedge clk_a); #2.5;
    chk("R1 held", state, '0);
    rst_ni = 1; model = '0;
    step(1'b1, 1'b1, '1, '1, "R1 restart");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule